// File: doc/BRIEF.md
# Vector Saturating Word Add Unit

This execution unit sits beside a 128-bit SIMD register file. Each cycle it may accept one 32-bit instruction word and two 128-bit source vectors that the register file has already read. Each vector holds four unsigned 32-bit lanes. The unit decodes two unsigned word-add instructions. The clamping form limits each lane sum to the largest unsigned word and reports any clamp through a sticky saturation flag. The wrapping form keeps the low 32 bits of each lane sum and leaves the flag untouched.

The result, the destination register index from the instruction and a valid strobe appear one clock after the instruction is accepted. A word the unit does not recognise raises an illegal-instruction strobe instead. A separate write port loads the vector status register, and software uses it to clear the sticky flag. That register also holds a mode bit that the adder never reads, and the write port stores it and returns it unchanged.

Top module: `vsat_word_adder`

## Requirements
- R1: An instruction is recognised when bits 31:26 (primary opcode, big-endian bits 0-5) equal 4. With extended opcode bits 10:0 equal to 640 it is the clamping add, so word 0x10000280 with all register fields zero is clamping. With extended opcode 128 it is the wrapping add. The destination index is taken from bits 25:21.
- R2: Clamping add: each lane result equals min(A+B, 0xFFFFFFFF), computed unsigned. Lane 0 is bits 127:96, lane 1 is bits 95:64, lane 2 is bits 63:32 and lane 3 is bits 31:0.
- R3: Overflow is decided by the carry out of a 33-bit sum. 0xFFFFFFFF+0 gives 0xFFFFFFFF and does not set the flag. 0xFFFFFFFF+1 clamps and sets the flag.
- R4: Wrapping add: each lane result equals (A+B) mod 2^32, and the saturation flag keeps its previous value.
- R5: A clamping add in which any lane clamps sets the saturation flag (status bit 0). No add instruction ever clears it.
- R6: A status write loads bit 0 (saturation) and bit 16 (non-Java mode) from the write data. `stat_q` returns both bits, and all other bits read 0. No add instruction changes bit 16.
- R7: If a status write and a clamping add that clamps occur on the same clock edge, the written value of bit 0 wins.
- R8: `res_valid` pulses for exactly one cycle, on the edge after a recognised instruction is accepted. That edge also loads `res_data` and `res_dst`, and both hold their values at all other times.
- R9: An unrecognised word with `ins_valid` high pulses `illegal` one cycle later. It raises no `res_valid` and changes neither `res_data` nor the status register.
- R10: While `rst_n` is low, `res_valid`, `illegal`, `res_data`, `res_dst` and `stat_q` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word and operands are presented this cycle |
| ins_word | input | 32 | Instruction word |
| src_a | input | 128 | First source vector, lane 0 in the top word |
| src_b | input | 128 | Second source vector, lane 0 in the top word |
| stat_wr_en | input | 1 | Load the status register from `stat_wr_data` |
| stat_wr_data | input | 32 | Status write value (bit 0 saturation, bit 16 mode) |
| res_valid | output | 1 | One-cycle strobe that a new result is present |
| res_data | output | 128 | Registered lane results |
| res_dst | output | 5 | Destination register index of the result |
| illegal | output | 1 | One-cycle strobe for an unrecognised instruction |
| stat_q | output | 32 | Current status register contents |

## Verification
The bench crosses eight boundary words in every lane under both add forms. A detector that uses a compare with an off-by-one error would clamp 0xFFFFFFFF+0 or miss 0xFFFFFFFE+1. A swapped lane order would show the right values in the wrong words. Clears are interleaved with clamping runs, so a flag that is not sticky, or one that an add can reset, reads back wrong. A test with a status write and a clamp on the same edge catches reversed priority. Illegal words, including a wrong primary opcode and neighbouring extended opcodes, expose a decoder that lets a result or a flag change slip through.

// File: rtl/vwadd_pkg.sv
package vwadd_pkg;
   localparam int INS_W     = 32;
   localparam int REG_IDX_W = 5;
   localparam int STAT_W    = 32;
   localparam int SAT_POS   = 0;
   localparam int NJ_POS    = 16;

   localparam logic [5:0]  PRIMARY_VEC = 6'd4;
   localparam logic [10:0] XO_ADD_CLAMP = 11'd640;
   localparam logic [10:0] XO_ADD_WRAP  = 11'd128;

   typedef enum logic [1:0] {
      OPK_NONE  = 2'd0,
      OPK_CLAMP = 2'd1,
      OPK_WRAP  = 2'd2
   } op_kind_e;
endpackage

// File: rtl/vwadd_decode.sv
module vwadd_decode
   import vwadd_pkg::*;
(
   input  logic [INS_W-1:0]     ins_word,
   output op_kind_e             kind,
   output logic [REG_IDX_W-1:0] dst_idx
);
   logic [5:0]  primary;
   logic [10:0] ext_op;
   logic        unused_src_fields;

   assign primary           = ins_word[31:26];
   assign ext_op            = ins_word[10:0];
   assign dst_idx           = ins_word[25:21];
   assign unused_src_fields = ^ins_word[20:11];

   always_comb begin
      kind = OPK_NONE;
      if (primary == PRIMARY_VEC) begin
         case (ext_op)
            XO_ADD_CLAMP: kind = OPK_CLAMP;
            XO_ADD_WRAP:  kind = OPK_WRAP;
            default:      kind = OPK_NONE;
         endcase
      end
   end
endmodule

// File: rtl/vwadd_lane.sv
module vwadd_lane #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W-1:0] a,
   input  logic [LANE_W-1:0] b,
   input  logic              clamp_en,
   output logic [LANE_W-1:0] y,
   output logic              carry
);
   localparam int SUM_W = LANE_W + 1;

   logic [SUM_W-1:0] sum;

   assign sum   = {1'b0, a} + {1'b0, b};
   assign carry = sum[SUM_W-1];

   always_comb begin
      if (clamp_en && carry) y = '1;
      else                   y = sum[LANE_W-1:0];
   end
endmodule

// File: rtl/vwadd_status.sv
module vwadd_status
   import vwadd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STAT_W-1:0] wr_data,
   input  logic              sat_set,
   output logic [STAT_W-1:0] stat_q
);
   generate
      if (SAT_POS == NJ_POS || SAT_POS >= STAT_W || NJ_POS >= STAT_W) begin : g_bad_layout
         $error("vwadd_status: status bit positions overlap or exceed the register");
      end
   endgenerate

   logic sat_q;
   logic nj_q;
   logic [STAT_W-1:0] unused_wr_bits;

   assign unused_wr_bits = wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sat_q <= 1'b0;
         nj_q  <= 1'b0;
      end else if (wr_en) begin
         sat_q <= wr_data[SAT_POS];
         nj_q  <= wr_data[NJ_POS];
      end else if (sat_set) begin
         sat_q <= 1'b1;
      end
   end

   always_comb begin
      stat_q          = '0;
      stat_q[SAT_POS] = sat_q;
      stat_q[NJ_POS]  = nj_q;
   end
endmodule

// File: rtl/vsat_word_adder.sv
module vsat_word_adder
   import vwadd_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int LANE_W = 32,
   localparam int VEC_W = LANES * LANE_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ins_valid,
   input  logic [INS_W-1:0]     ins_word,
   input  logic [VEC_W-1:0]     src_a,
   input  logic [VEC_W-1:0]     src_b,
   input  logic                 stat_wr_en,
   input  logic [STAT_W-1:0]    stat_wr_data,
   output logic                 res_valid,
   output logic [VEC_W-1:0]     res_data,
   output logic [REG_IDX_W-1:0] res_dst,
   output logic                 illegal,
   output logic [STAT_W-1:0]    stat_q
);
   generate
      if (LANES < 1)  begin : g_bad_lanes $error("vsat_word_adder: LANES must be at least 1"); end
      if (LANE_W < 2) begin : g_bad_width $error("vsat_word_adder: LANE_W must be at least 2"); end
   endgenerate

   op_kind_e             kind;
   logic [REG_IDX_W-1:0] dst_idx;
   logic                 clamp_en;
   logic [LANES-1:0]     lane_carry;
   logic [VEC_W-1:0]     lane_sum;
   logic                 accept;
   logic                 sat_set;

   vwadd_decode u_dec (
      .ins_word (ins_word),
      .kind     (kind),
      .dst_idx  (dst_idx)
   );

   assign clamp_en = (kind == OPK_CLAMP);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int TOP = VEC_W - 1 - k * LANE_W;
      vwadd_lane #(.LANE_W(LANE_W)) u_lane (
         .a        (src_a[TOP -: LANE_W]),
         .b        (src_b[TOP -: LANE_W]),
         .clamp_en (clamp_en),
         .y        (lane_sum[TOP -: LANE_W]),
         .carry    (lane_carry[k])
      );
   end

   assign accept  = ins_valid && (kind != OPK_NONE);
   assign sat_set = ins_valid && clamp_en && (|lane_carry);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         illegal   <= 1'b0;
         res_data  <= '0;
         res_dst   <= '0;
      end else begin
         res_valid <= accept;
         illegal   <= ins_valid && (kind == OPK_NONE);
         if (accept) begin
            res_data <= lane_sum;
            res_dst  <= dst_idx;
         end
      end
   end

   vwadd_status u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (stat_wr_en),
      .wr_data (stat_wr_data),
      .sat_set (sat_set),
      .stat_q  (stat_q)
   );
endmodule

// File: rtl/vwadd_chk.sv
module vwadd_chk
   import vwadd_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ins_valid,
   input logic              stat_wr_en,
   input logic [STAT_W-1:0] stat_wr_data,
   input logic              res_valid,
   input logic [VEC_W-1:0]  res_data,
   input logic              illegal,
   input logic [STAT_W-1:0] stat_q
);
   // R8: a result strobe needs an instruction on the prior edge
   p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(ins_valid));

   // R8: data only moves together with the strobe
   p_hold_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(res_data));

   // R9: illegal and a result are never reported together
   p_illegal_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(res_valid && illegal));

   // R9: an illegal word leaves status alone unless software wrote it
   p_illegal_stat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (illegal && !$past(stat_wr_en)) |-> $stable(stat_q));

   // R5: the sticky flag survives any cycle without a status write
   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[SAT_POS] && !stat_wr_en) |=> stat_q[SAT_POS]);

   // R6: the mode bit only moves on a status write
   p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_wr_en |=> $stable(stat_q[NJ_POS]));

   // R7: a write decides the flag regardless of a concurrent clamp
   p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr_en |=> (stat_q[SAT_POS] == $past(stat_wr_data[SAT_POS])));
endmodule

bind vsat_word_adder vwadd_chk #(.VEC_W(VEC_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ins_valid    (ins_valid),
   .stat_wr_en   (stat_wr_en),
   .stat_wr_data (stat_wr_data),
   .res_valid    (res_valid),
   .res_data     (res_data),
   .illegal      (illegal),
   .stat_q       (stat_q)
);

// File: tb/sim_vsat_word_adder.sv
`timescale 1ns/1ps
module sim_vsat_word_adder;
   localparam int LANES  = 4;
   localparam int LANE_W = 32;
   localparam int VEC_W  = LANES * LANE_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ins_valid = 1'b0;
   logic [31:0]       ins_word = '0;
   logic [VEC_W-1:0]  src_a = '0;
   logic [VEC_W-1:0]  src_b = '0;
   logic              stat_wr_en = 1'b0;
   logic [31:0]       stat_wr_data = '0;
   logic              res_valid;
   logic [VEC_W-1:0]  res_data;
   logic [4:0]        res_dst;
   logic              illegal;
   logic [31:0]       stat_q;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic exp_sat = 1'b0;
   logic exp_nj  = 1'b0;
   logic [31:0] corner [8];

   always #10 clk = ~clk;

   vsat_word_adder #(.LANES(LANES), .LANE_W(LANE_W)) u0 (
      .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
      .src_a(src_a), .src_b(src_b), .stat_wr_en(stat_wr_en),
      .stat_wr_data(stat_wr_data), .res_valid(res_valid), .res_data(res_data),
      .res_dst(res_dst), .illegal(illegal), .stat_q(stat_q)
   );

   function automatic logic [31:0] mk_word(input logic [5:0] prim, input logic [4:0] rd,
                                            input logic [10:0] xo);
      return {prim, rd, 5'd3, 5'd7, xo};
   endfunction

   function automatic logic [31:0] exp_stat();
      logic [31:0] s = '0;
      s[0]  = exp_sat;
      s[16] = exp_nj;
      return s;
   endfunction

   task automatic chk(input string req, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive one cycle of inputs at a falling edge; sample after the next rising edge.
   task automatic cycle(input logic iv, input logic [31:0] w, input logic [VEC_W-1:0] a,
                        input logic [VEC_W-1:0] b, input logic we, input logic [31:0] wd);
      @(negedge clk);
      ins_valid = iv; ins_word = w; src_a = a; src_b = b;
      stat_wr_en = we; stat_wr_data = wd;
      @(negedge clk);
      ins_valid = 1'b0; stat_wr_en = 1'b0;
   endtask

   task automatic write_stat(input logic sat, input logic nj);
      logic [31:0] wd = 32'hA5A5_5A5A;
      wd[0] = sat; wd[16] = nj;
      cycle(1'b0, '0, '0, '0, 1'b1, wd);
      exp_sat = sat; exp_nj = nj;
      chk("R6 status write readback", stat_q, exp_stat());
   endtask

   // Apply one add and check the result, the destination, the strobes and the status.
   task automatic run_add(input bit clamp, input logic [4:0] rd,
                          input logic [VEC_W-1:0] a, input logic [VEC_W-1:0] b, input string req);
      logic [VEC_W-1:0] e;
      logic any = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         logic [32:0] s;
         s = {1'b0, a[VEC_W-1-k*32 -: 32]} + {1'b0, b[VEC_W-1-k*32 -: 32]};
         if (clamp && s[32]) e[VEC_W-1-k*32 -: 32] = 32'hFFFF_FFFF;
         else                e[VEC_W-1-k*32 -: 32] = s[31:0];
         any |= s[32];
      end
      if (clamp && any) exp_sat = 1'b1;
      cycle(1'b1, mk_word(6'd4, rd, clamp ? 11'd640 : 11'd128), a, b, 1'b0, '0);
      chk(req, res_data, e);
      chk("R8 strobe and R1 dest", {res_valid, illegal, res_dst}, {1'b1, 1'b0, rd});
      chk(clamp ? "R5 sticky flag" : "R4 flag untouched", stat_q, exp_stat());
   endtask

   initial begin
      corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'h0000_0002;
      corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000; corner[5] = 32'hFFFF_FFFD;
      corner[6] = 32'hFFFF_FFFE; corner[7] = 32'hFFFF_FFFF;

      // R10 reset state
      repeat (3) @(negedge clk);
      chk("R10 reset outputs", {res_valid, illegal, res_dst, stat_q}, '0);
      chk("R10 reset data", res_data, '0);
      rst_n = 1'b1;

      // R1 exact word 0x10000280 is the clamping add
      cycle(1'b1, 32'h1000_0280, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, 1'b0, '0);
      exp_sat = 1'b1;
      chk("R1 word 0x10000280 clamps", res_data, {4{32'hFFFF_FFFF}});
      chk("R1 word 0x10000280 flag", stat_q, exp_stat());

      // R6 clear, with the mode bit set
      write_stat(1'b0, 1'b1);

      // R3 carry boundary in lane 0 only, other lanes small
      run_add(1'b1, 5'd9, {32'hFFFF_FFFF, 32'd5, 32'd6, 32'd7}, {32'd0, 32'd1, 32'd1, 32'd1}, "R3 max+0 no clamp");
      chk("R3 max+0 leaves flag clear", stat_q[0], '0);
      run_add(1'b1, 5'd10, {32'hFFFF_FFFF, 32'd5, 32'd6, 32'd7}, {32'd1, 32'd1, 32'd1, 32'd1}, "R3 max+1 clamps lane0 R2");
      chk("R3 max+1 sets flag", stat_q[0], 1'b1);

      // R7 same-edge write beats a clamping add; then a wrapping add keeps a written 1 (R4)
      begin
         logic [31:0] wd = '0;
         wd[16] = 1'b1;
         cycle(1'b1, mk_word(6'd4, 5'd1, 11'd640), {4{32'hF000_0000}}, {4{32'h2000_0000}}, 1'b1, wd);
         exp_sat = 1'b0;
         chk("R7 write wins over clamp", stat_q, exp_stat());
         chk("R7 result still clamped R2", res_data, {4{32'hFFFF_FFFF}});
      end
      run_add(1'b0, 5'd2, {4{32'hF000_0000}}, {4{32'h2000_0000}}, "R4 wrap result");

      // Near-exhaustive sweep over corner pairs in all lanes, both forms
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            logic [VEC_W-1:0] a, b;
            for (int k = 0; k < LANES; k++) begin
               a[VEC_W-1-k*32 -: 32] = corner[(i + k) % 8];
               b[VEC_W-1-k*32 -: 32] = corner[(j + 3 * k) % 8];
            end
            if ((i + j) % 3 == 0) write_stat(1'b0, i[0]);
            run_add(1'b1, 5'((i * 8 + j) % 32), a, b, "R2 clamp sweep");
            run_add(1'b0, 5'((i * 8 + j + 5) % 32), a, b, "R4 wrap sweep");
         end
      end

      // R9 illegal words: wrong primary, neighbouring extended opcodes
      write_stat(1'b1, 1'b0);
      begin
         logic [VEC_W-1:0] held;
         logic [31:0] bad [3];
         bad[0] = mk_word(6'd5, 5'd4, 11'd640);
         bad[1] = mk_word(6'd4, 5'd4, 11'd641);
         bad[2] = mk_word(6'd4, 5'd4, 11'd0);
         write_stat(1'b0, 1'b1);
         for (int n = 0; n < 3; n++) begin
            held = res_data;
            cycle(1'b1, bad[n], {4{32'hFFFF_FFFF}}, {4{32'hFFFF_FFFF}}, 1'b0, '0);
            chk("R9 illegal strobe, no result", {illegal, res_valid}, {1'b1, 1'b0});
            chk("R9 data unchanged", res_data, held);
            chk("R9 status unchanged", stat_q, exp_stat());
         end
         // R8 strobe lasts one cycle and data holds while idle
         run_add(1'b0, 5'd31, {32'd1, 32'd2, 32'd3, 32'd4}, {32'd10, 32'd20, 32'd30, 32'd40}, "R8 wrap small");
         held = res_data;
         @(negedge clk);
         chk("R8 strobes drop", {res_valid, illegal}, 2'b00);
         chk("R8 data holds", res_data, held);
         chk("R8 data lane order R2", held, {32'd11, 32'd22, 32'd33, 32'd44});
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule